// File: doc/BRIEF.md
# Four-Channel PWM Timer

This block is an up-counting timer that produces four pulse-width-modulated output pins from one shared time base. A prescaler divides the input clock so that the counter advances once every (prescale + 1) clocks. The counter runs from zero to a programmable period value and then wraps back to zero. Each of the four channels compares the running count with its own 16-bit threshold, or is forced to a fixed level, according to a 3-bit mode field. The result is then gated by a per-channel enable and optionally inverted before it reaches the pin.

Software programs the block through a small synchronous register port. It uses a 4-bit word address and a one-cycle write strobe, and read data follows the address combinationally. The period register can be buffered: while buffering is on, a new period waits in a holding register and becomes active only when the counter wraps. This keeps the current cycle intact. The threshold comparison is kept deliberately plain. A threshold equal to the period therefore still leaves a one-tick low pulse at the top of each cycle, and a steady high output has to come from the forced-high mode.

Top module: `pwm4_timer`

## Requirements
- R1: After reset all four pins are 0. The period register reads 0xFFFF, and every other register reads 0.
- R2: Register words are: 0 control, 1 mode A, 2 mode B, 3 channel enable, 4 prescale, 5 period, 6 to 9 thresholds of channels 0 to 3. A read returns the written value masked to the implemented bits (control 0x0003, mode 0x7070, enable 0x3333, others 0xFFFF). Words 10 to 15 read 0, and writes to them have no effect.
- R3: While running, the counter advances exactly once every (prescale + 1) clocks.
- R4: The counter counts from 0 up to the active period value and on the next tick wraps to 0.
- R5: Control bit 0 is the run bit. While it is 0, the counter and all pins hold their values.
- R6: Control bit 1 is the period-buffer bit. When it is set, a period write is held and becomes active at the next wrap. When it is clear, the write takes effect on the next clock.
- R7: Mode code 6 is PWM mode 1. The reference level is 1 while count < threshold and 0 otherwise, so a threshold equal to the period gives one low tick per cycle.
- R8: Mode code 4 forces the reference level to 0, and mode code 5 forces it to 1. All other codes also give 0.
- R9: In the enable register, channel c owns bits 4c (enable) and 4c+1 (invert). A disabled channel drives 0, and an enabled one drives the reference level XOR invert.
- R10: The mode field of channel 0 is mode A bits [6:4], and channel 1 is mode A bits [14:12]. Channels 2 and 3 use the same positions in mode B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | 4 | Register word address for write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| pwm_out | output | 4 | Channel pins after enable and polarity |

## Verification
A wrong prescale or count state shows up as a shifted pin edge. It is visible within one period of the affected channel, and the bench compares every pin on every clock with its own model of the count. A period buffer that loads at the wrong moment moves the edge only in the cycle after the write. The bench therefore writes a new period in mid-cycle, both with buffering on and with buffering off. A misplaced mode field or enable bit shows up at once as a pin driven on the wrong channel. Dedicated checks write a single field and watch its neighbour.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam int AW  = 4;
    localparam int MW  = 3;

    localparam logic [MW-1:0] MODE_LOW  = 3'd4;
    localparam logic [MW-1:0] MODE_HIGH = 3'd5;
    localparam logic [MW-1:0] MODE_PWM1 = 3'd6;

    localparam logic [AW-1:0] A_CTRL  = 4'd0;
    localparam logic [AW-1:0] A_MODEA = 4'd1;
    localparam logic [AW-1:0] A_MODEB = 4'd2;
    localparam logic [AW-1:0] A_ENBL  = 4'd3;
    localparam logic [AW-1:0] A_PSC   = 4'd4;
    localparam logic [AW-1:0] A_PER   = 4'd5;
    localparam logic [AW-1:0] A_CMP0  = 4'd6;

    // first channel of a pair at bit 4, second at bit 12
    function automatic int mode_lsb(input int ch);
        return ((ch % 2) == 0) ? 4 : 12;
    endfunction

    typedef struct packed {
        logic                     run;
        logic                     buf_en;
        logic [NCH-1:0][MW-1:0]   mode;
        logic [NCH-1:0]           en;
        logic [NCH-1:0]           inv;
        logic [DW-1:0]            psc;
        logic [DW-1:0]            per_hold;
        logic [NCH-1:0][DW-1:0]   thr;
    } regs_t;

    typedef struct packed {
        logic [DW-1:0] pc;
        logic [DW-1:0] cnt;
        logic [DW-1:0] per;
    } cnt_t;
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
    import pwm4_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wr_data,
    output logic [DW-1:0]          rd_data,
    output regs_t                  regs_o
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (addr == A_CTRL) begin
                r_d.run    = wr_data[0];
                r_d.buf_en = wr_data[1];
            end
            if (addr == A_PSC) r_d.psc      = wr_data;
            if (addr == A_PER) r_d.per_hold = wr_data;
            for (int c = 0; c < NCH; c++) begin
                if (addr == AW'(int'(A_MODEA) + c / 2))
                    r_d.mode[c] = wr_data[mode_lsb(c) +: MW];
                if (addr == A_ENBL) begin
                    r_d.en[c]  = wr_data[4*c];
                    r_d.inv[c] = wr_data[4*c+1];
                end
                if (addr == AW'(int'(A_CMP0) + c))
                    r_d.thr[c] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q          <= '0;
            r_q.per_hold <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == A_CTRL) rd_data[1:0] = {r_q.buf_en, r_q.run};
        if (addr == A_PSC)  rd_data = r_q.psc;
        if (addr == A_PER)  rd_data = r_q.per_hold;
        for (int c = 0; c < NCH; c++) begin
            if (addr == AW'(int'(A_MODEA) + c / 2))
                rd_data[mode_lsb(c) +: MW] = r_q.mode[c];
            if (addr == A_ENBL) begin
                rd_data[4*c]   = r_q.en[c];
                rd_data[4*c+1] = r_q.inv[c];
            end
            if (addr == AW'(int'(A_CMP0) + c))
                rd_data = r_q.thr[c];
        end
    end

    assign regs_o = r_q;
endmodule

// File: rtl/pwm4_count.sv
module pwm4_count
    import pwm4_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic          buf_i,
    input  logic [DW-1:0] psc_i,
    input  logic          per_wr_i,
    input  logic [DW-1:0] per_wdata_i,
    input  logic [DW-1:0] per_hold_i,
    output logic [DW-1:0] cnt_o
);
    cnt_t c_d, c_q;
    logic tick, wrap;

    always_comb begin
        c_d  = c_q;
        tick = run_i && (c_q.pc >= psc_i);
        wrap = tick && (c_q.cnt >= c_q.per);
        if (tick)       c_d.pc = '0;
        else if (run_i) c_d.pc = c_q.pc + 1'b1;
        if (wrap)       c_d.cnt = '0;
        else if (tick)  c_d.cnt = c_q.cnt + 1'b1;
        if (per_wr_i && !buf_i) c_d.per = per_wdata_i;
        else if (wrap)          c_d.per = per_hold_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q     <= '0;
            c_q.per <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_o = c_q.cnt;

    a_r3_tick_restart: assert property (@(posedge clk) disable iff (rst)
        tick |=> (c_q.pc == '0));
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (tick && (c_q.cnt >= c_q.per)) |=> (cnt_o == '0));
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> ($stable(c_q.cnt) && $stable(c_q.pc)));
    a_r6_buffered: assert property (@(posedge clk) disable iff (rst)
        (buf_i && !(tick && (c_q.cnt >= c_q.per))) |=> $stable(c_q.per));
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
    import pwm4_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [MW-1:0] mode_i,
    input  logic [DW-1:0] thr_i,
    input  logic [DW-1:0] cnt_i,
    input  logic          en_i,
    input  logic          inv_i,
    output logic          pin_o
);
    logic lvl;

    always_comb begin
        case (mode_i)
            MODE_HIGH: lvl = 1'b1;
            MODE_PWM1: lvl = (cnt_i < thr_i);
            MODE_LOW:  lvl = 1'b0;
            default:   lvl = 1'b0;
        endcase
        pin_o = en_i & (lvl ^ inv_i);
    end

    a_r7_zero_thr_low: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_PWM1 && thr_i == '0 && en_i) |-> (pin_o == inv_i));
    a_r9_disabled_low: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> !pin_o);
endmodule

// File: rtl/pwm4_timer.sv
module pwm4_timer
    import pwm4_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [3:0]    addr,
    input  logic [15:0]   wr_data,
    output logic [15:0]   rd_data,
    output logic [3:0]    pwm_out
);
    regs_t         regs;
    logic [DW-1:0] cnt;
    logic          per_wr;

    assign per_wr = wr_en && (addr == A_PER);

    pwm4_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .regs_o(regs)
    );

    pwm4_count u_count (
        .clk(clk), .rst(rst), .run_i(regs.run), .buf_i(regs.buf_en),
        .psc_i(regs.psc), .per_wr_i(per_wr), .per_wdata_i(wr_data),
        .per_hold_i(regs.per_hold), .cnt_o(cnt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm4_chan u_ch (
            .clk(clk), .rst(rst), .mode_i(regs.mode[c]), .thr_i(regs.thr[c]),
            .cnt_i(cnt), .en_i(regs.en[c]), .inv_i(regs.inv[c]),
            .pin_o(pwm_out[c])
        );
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (pwm_out == '0));
endmodule

// File: tb/pwm4_timer_test.sv
module pwm4_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [3:0]  pwm_out;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwm4_timer uut (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out));

    // bench model
    logic m_run, m_buf;
    logic [2:0] m_mode [4];
    logic m_en [4], m_inv [4];
    logic [15:0] m_psc, m_hold, m_per, m_cnt, m_pc;
    logic [15:0] m_thr [4];

    always @(posedge clk) begin : mdl
        logic tk, wp;
        if (rst) begin
            m_run <= 0; m_buf <= 0; m_psc <= 0; m_hold <= 16'hFFFF;
            m_per <= 16'hFFFF; m_cnt <= 0; m_pc <= 0;
            for (int c = 0; c < 4; c++) begin
                m_mode[c] <= 0; m_en[c] <= 0; m_inv[c] <= 0; m_thr[c] <= 0;
            end
        end else begin
            tk = m_run && (m_pc >= m_psc);
            wp = tk && (m_cnt >= m_per);
            m_pc  <= tk ? 16'd0 : (m_run ? m_pc + 16'd1 : m_pc);
            m_cnt <= wp ? 16'd0 : (tk ? m_cnt + 16'd1 : m_cnt);
            if (wr_en && addr == 4'd5 && !m_buf) m_per <= wr_data;
            else if (wp) m_per <= m_hold;
            if (wr_en) begin
                case (addr)
                    4'd0: begin m_run <= wr_data[0]; m_buf <= wr_data[1]; end
                    4'd1: begin m_mode[0] <= wr_data[6:4]; m_mode[1] <= wr_data[14:12]; end
                    4'd2: begin m_mode[2] <= wr_data[6:4]; m_mode[3] <= wr_data[14:12]; end
                    4'd3: for (int c = 0; c < 4; c++) begin
                              m_en[c] <= wr_data[4*c]; m_inv[c] <= wr_data[4*c+1];
                          end
                    4'd4: m_psc <= wr_data;
                    4'd5: m_hold <= wr_data;
                    4'd6, 4'd7, 4'd8, 4'd9: m_thr[addr-4'd6] <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic exp_pin(input int c);
        logic lvl;
        case (m_mode[c])
            3'd5: lvl = 1'b1;
            3'd6: lvl = (m_cnt < m_thr[c]);
            default: lvl = 1'b0;
        endcase
        return m_en[c] & (lvl ^ m_inv[c]);
    endfunction

    function automatic string ch_tag(input int c);
        if (!m_en[c]) return "R9";
        if (m_mode[c] == 3'd6) return "R7";
        return "R8";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, {16'd0, rd_data}, {16'd0, exp});
    endtask

    // compare pins with model on each cycle; empty tag uses per-channel tag
    task automatic run_check(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            for (int c = 0; c < 4; c++)
                check(tag == "" ? ch_tag(c) : tag, {31'd0, pwm_out[c]}, {31'd0, exp_pin(c)});
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hi, lo;
        int unsigned seed;
        seed = $urandom(32'd2024);
        do_reset();

        // R1 reset state
        #1; check("R1 pins", {28'd0, pwm_out}, 32'd0);
        rd_check(4'd0, 16'h0000, "R1 ctrl");
        rd_check(4'd5, 16'hFFFF, "R1 period");
        rd_check(4'd3, 16'h0000, "R1 enable");
        rd_check(4'd4, 16'h0000, "R1 prescale");
        rd_check(4'd8, 16'h0000, "R1 thr2");

        // R2 readback with masks
        wr(4'd0, 16'hFFFC); rd_check(4'd0, 16'h0000, "R2 ctrl mask");
        wr(4'd1, 16'hFFFF); rd_check(4'd1, 16'h7070, "R2 modeA mask");
        wr(4'd2, 16'h5A5A); rd_check(4'd2, 16'h5050, "R2 modeB mask");
        wr(4'd3, 16'hFFFF); rd_check(4'd3, 16'h3333, "R2 enable mask");
        wr(4'd4, 16'h1234); rd_check(4'd4, 16'h1234, "R2 prescale");
        wr(4'd9, 16'hBEEF); rd_check(4'd9, 16'hBEEF, "R2 thr3");
        wr(4'd12, 16'hFFFF); rd_check(4'd12, 16'h0000, "R2 unmapped");
        rd_check(4'd6, 16'h0000, "R2 thr0 untouched");

        // R10 field positions: only ch3 forced high
        do_reset();
        wr(4'd3, 16'h1111);
        wr(4'd2, 16'h5000);
        #1; check("R10 ch3 high", {31'd0, pwm_out[3]}, 32'd1);
        check("R10 ch2 low", {31'd0, pwm_out[2]}, 32'd0);
        wr(4'd1, 16'h0050);
        #1; check("R10 ch0 high", {31'd0, pwm_out[0]}, 32'd1);
        check("R10 ch1 low", {31'd0, pwm_out[1]}, 32'd0);

        // R3/R4: prescale 3, period 10, threshold 2
        do_reset();
        wr(4'd4, 16'd3); wr(4'd5, 16'd10); wr(4'd6, 16'd2);
        wr(4'd1, 16'h0060); wr(4'd3, 16'h0001);
        wr(4'd0, 16'h0001);
        hi = 0; lo = 0;
        #1;
        while (pwm_out[0] && hi < 100) begin hi++; @(negedge clk); #1; end
        check("R3 high ticks*4", hi, 8);
        while (!pwm_out[0] && lo < 100) begin lo++; @(negedge clk); #1; end
        check("R4 low span", lo, 36);
        run_check(100, "R4");

        // R5 run cleared holds
        wr(4'd0, 16'h0000);
        run_check(60, "R5");

        // R6 buffered and direct period writes mid-cycle
        do_reset();
        wr(4'd5, 16'd9); wr(4'd6, 16'd4); wr(4'd1, 16'h0060); wr(4'd3, 16'h0003);
        wr(4'd0, 16'h0003);
        run_check(6, "R6");
        wr(4'd5, 16'd3);
        run_check(30, "R6");
        wr(4'd0, 16'h0001);
        wr(4'd5, 16'd12);
        run_check(6, "R6");
        wr(4'd5, 16'd2);
        run_check(30, "R6");

        // R7 threshold equal to period: one low tick per cycle
        do_reset();
        wr(4'd5, 16'd5); wr(4'd7, 16'd5); wr(4'd1, 16'h6000); wr(4'd3, 16'h0010);
        wr(4'd0, 16'h0001);
        lo = 0;
        for (int i = 0; i < 24; i++) begin @(negedge clk); #1; if (!pwm_out[1]) lo++; end
        check("R7 glitch count", lo, 4);
        run_check(20, "R7");

        // random
        for (int s = 0; s < 40; s++) begin
            logic [15:0] per;
            per = 16'($urandom_range(2, 20));
            wr(4'd4, 16'($urandom_range(0, 3)));
            wr(4'd5, per);
            for (int c = 0; c < 4; c++) wr(4'(6 + c), 16'($urandom_range(0, per + 2)));
            wr(4'd1, {1'b0, 3'($urandom), 5'd0, 3'($urandom), 4'd0});
            wr(4'd2, {1'b0, 3'($urandom_range(4, 6)), 5'd0, 3'($urandom_range(4, 6)), 4'd0});
            wr(4'd3, 16'($urandom) & 16'h3333);
            wr(4'd0, {14'd0, 1'($urandom), 1'b1});
            run_check(150, "");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule